// File: doc/BRIEF.md
# Timing Event Logger with Rate Limiting

The logger sits next to a reference-source selector in a frequency distribution chain. Each cycle the selector may offer one timing event. An event carries its type, the source it moved from and to, and the inputs behind the decision: quality level, priority rank and timer flags. It also carries two reason codes, the lock state, a drift indicator, an opaque environment snapshot from the temperature and supply monitors, and the active configuration profile. The logger stamps the event with a free-running local time and packs everything into one record. The record goes into a 16-entry queue that software drains through a valid/ready port.

A token bucket limits how many events reach the queue. A burst of alarms therefore produces at most a bounded number of records. Events that find the bucket empty are discarded and counted. Per-type counters and a counter of events that change source see every offered event, whether or not it is logged. A sticky flag shows that an admitted record was lost because the queue was full.

Top module: `tevt_logger`

## Requirements
- R1: After reset the queue is empty (`rec_valid` low), every counter reads zero, `overflow` is low and the bucket holds `BURST` tokens.
- R2: The timestamp is a `TS_W`-bit counter. It reads 0 in the first cycle after reset, advances by one every cycle and wraps silently from all-ones to zero. A record's timestamp is the counter value in the cycle the event was offered.
- R3: An admitted event appears as a record on `rec_ts`/`rec_info` in the next cycle, provided the queue had room. `rec_info` packs its fields from the MSB down as: type(2), from(4), to(4), quality(4), priority(3), timers(3: gate, wtr, holdoff), primary reason(4), secondary reason(4), state(2), drift(8), snapshot(16), profile(4).
- R4: Every offered event increments `type_cnt` slice number *type*, where type codes are 0 signal loss, 1 quality degrade, 2 manual switch and 3 internal fault. Slice *k* is `type_cnt[k*CNT_W +: CNT_W]`. The count is taken whether the event is logged or not.
- R5: `switch_cnt` increments for every offered event whose from-source differs from its to-source.
- R6: An offered event is admitted only if the bucket holds at least one token, and admission takes one token. A refill counter runs from reset and adds one token every `REFILL_PERIOD` cycles, never above `BURST`. A token taken and a token added in the same cycle cancel.
- R7: An event offered with the bucket empty is not queued, and `drop_cnt` increments by one.
- R8: The queue returns records in arrival order. An admitted event that arrives while 16 records are held is discarded, even if a record is read in that cycle. It still takes its token, and it sets `overflow`, which stays high until reset.
- R9: A record stays unchanged on the outputs while `rec_valid` is high and `rec_ready` is low. A record is removed on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_type | input | 2 | Event type code |
| ev_from | input | 4 | Source ID before the event |
| ev_to | input | 4 | Source ID after the event |
| ev_ql | input | 4 | Quality level of the selected source |
| ev_prio | input | 3 | Priority rank |
| ev_timers | input | 3 | Timer-active flags: bit2 gate, bit1 wait-to-restore, bit0 holdoff |
| ev_rsn_pri | input | 4 | Primary reason code |
| ev_rsn_sec | input | 4 | Secondary reason code |
| ev_state | input | 2 | Lock state: 0 locked, 1 holdover, 2 reacquire |
| ev_drift | input | 8 | Drift indicator word |
| ev_snap | input | 16 | Environment snapshot word |
| ev_profile | input | 4 | Configuration profile ID |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Reader accepts the record |
| rec_ts | output | TS_W | Record timestamp |
| rec_info | output | 58 | Record body, layout as in R3 |
| type_cnt | output | 4*CNT_W | Per-type event counters |
| switch_cnt | output | CNT_W | Source-change event counter |
| drop_cnt | output | CNT_W | Rate-limited event counter |
| overflow | output | 1 | Sticky queue-overflow flag |

## Verification
Every result is due one clock edge after the event that causes it. This covers a counter step, a new head record, a token taken or the overflow flag. A cycle-level model in the bench advances at each rising edge from the same inputs. The bench then compares all outputs against that model at the following falling edge, so each comparison lands exactly one register stage after its cause. Timestamps in the expected records are the model's cycle count since reset, reduced modulo 2^TS_W. With the 8-bit timestamp and 8-cycle refill used here, a run of a few hundred cycles crosses the wrap point and empties the bucket several times.

// File: rtl/tevt_pkg.sv
package tevt_pkg;

    localparam int SRC_W   = 4;
    localparam int QL_W    = 4;
    localparam int PRIO_W  = 3;
    localparam int RSN_W   = 4;
    localparam int DRIFT_W = 8;
    localparam int SNAP_W  = 16;
    localparam int PROF_W  = 4;
    localparam int NTYPES  = 4;

    typedef enum logic [1:0] {
        EV_LOSS    = 2'd0,
        EV_DEGRADE = 2'd1,
        EV_MANUAL  = 2'd2,
        EV_FAULT   = 2'd3
    } ev_type_e;

    typedef enum logic [1:0] {
        ST_LOCKED    = 2'd0,
        ST_HOLDOVER  = 2'd1,
        ST_REACQUIRE = 2'd2,
        ST_RSVD      = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic gate;
        logic wtr;
        logic holdoff;
    } timer_flags_t;

    typedef struct packed {
        ev_type_e            etype;
        logic [SRC_W-1:0]    src_from;
        logic [SRC_W-1:0]    src_to;
        logic [QL_W-1:0]     ql;
        logic [PRIO_W-1:0]   prio;
        timer_flags_t        timers;
        logic [RSN_W-1:0]    rsn_pri;
        logic [RSN_W-1:0]    rsn_sec;
        lock_state_e         state;
        logic [DRIFT_W-1:0]  drift;
        logic [SNAP_W-1:0]   snap;
        logic [PROF_W-1:0]   profile;
    } rec_info_t;

    localparam int INFO_W = $bits(rec_info_t);

    function automatic logic moves_source(input logic [SRC_W-1:0] a,
                                          input logic [SRC_W-1:0] b);
        return a != b;
    endfunction

endpackage

// File: rtl/tevt_tokens.sv
module tevt_tokens #(
    parameter int BURST         = 4,
    parameter int REFILL_PERIOD = 1000,
    localparam int TOK_W = $clog2(BURST + 1),
    localparam int RC_W  = (REFILL_PERIOD > 1) ? $clog2(REFILL_PERIOD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    output logic             grant,
    output logic [TOK_W-1:0] level
);
    logic [TOK_W-1:0] tok_q, tok_d;
    logic [RC_W-1:0]  rc_q;
    logic             tick;

    assign tick  = (rc_q == RC_W'(REFILL_PERIOD - 1));
    assign grant = req && (tok_q != '0);
    assign level = tok_q;

    always_comb begin
        tok_d = tok_q;
        if (grant)
            tok_d = tok_d - 1'b1;
        if (tick && (tok_d != TOK_W'(BURST)))
            tok_d = tok_d + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= TOK_W'(BURST);
            rc_q  <= '0;
        end else begin
            tok_q <= tok_d;
            rc_q  <= tick ? '0 : rc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tevt_fifo.sv
module tevt_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rp_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push)
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tevt_counters.sv
module tevt_counters
    import tevt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_valid,
    input  ev_type_e                etype,
    input  logic                    is_switch,
    input  logic                    dropped,
    output logic [NTYPES*CNT_W-1:0] type_cnt,
    output logic [CNT_W-1:0]        switch_cnt,
    output logic [CNT_W-1:0]        drop_cnt
);
    for (genvar k = 0; k < NTYPES; k++) begin : g_type
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst)
                c_q <= '0;
            else if (ev_valid && (etype == ev_type_e'(k)))
                c_q <= c_q + 1'b1;
        end
        assign type_cnt[k*CNT_W +: CNT_W] = c_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            switch_cnt <= '0;
            drop_cnt   <= '0;
        end else begin
            if (ev_valid && is_switch)
                switch_cnt <= switch_cnt + 1'b1;
            if (dropped)
                drop_cnt <= drop_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tevt_logger.sv
module tevt_logger
    import tevt_pkg::*;
#(
    parameter int TS_W          = 32,
    parameter int BURST         = 4,
    parameter int REFILL_PERIOD = 1000,
    parameter int DEPTH         = 16,
    parameter int CNT_W         = 16,
    localparam int REC_W = TS_W + INFO_W,
    localparam int TOK_W = $clog2(BURST + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_valid,
    input  logic [1:0]              ev_type,
    input  logic [SRC_W-1:0]        ev_from,
    input  logic [SRC_W-1:0]        ev_to,
    input  logic [QL_W-1:0]         ev_ql,
    input  logic [PRIO_W-1:0]       ev_prio,
    input  logic [2:0]              ev_timers,
    input  logic [RSN_W-1:0]        ev_rsn_pri,
    input  logic [RSN_W-1:0]        ev_rsn_sec,
    input  logic [1:0]              ev_state,
    input  logic [DRIFT_W-1:0]      ev_drift,
    input  logic [SNAP_W-1:0]       ev_snap,
    input  logic [PROF_W-1:0]       ev_profile,
    output logic                    rec_valid,
    input  logic                    rec_ready,
    output logic [TS_W-1:0]         rec_ts,
    output logic [INFO_W-1:0]       rec_info,
    output logic [NTYPES*CNT_W-1:0] type_cnt,
    output logic [CNT_W-1:0]        switch_cnt,
    output logic [CNT_W-1:0]        drop_cnt,
    output logic                    overflow
);
    logic [TS_W-1:0]  ts_q;
    logic             grant, fifo_full;
    logic [TOK_W-1:0] tok_level;
    rec_info_t        info;
    logic [REC_W-1:0] rec_word;

    always_comb begin
        info.etype    = ev_type_e'(ev_type);
        info.src_from = ev_from;
        info.src_to   = ev_to;
        info.ql       = ev_ql;
        info.prio     = ev_prio;
        info.timers   = timer_flags_t'(ev_timers);
        info.rsn_pri  = ev_rsn_pri;
        info.rsn_sec  = ev_rsn_sec;
        info.state    = lock_state_e'(ev_state);
        info.drift    = ev_drift;
        info.snap     = ev_snap;
        info.profile  = ev_profile;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q     <= '0;
            overflow <= 1'b0;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (grant && fifo_full)
                overflow <= 1'b1;
        end
    end

    tevt_tokens #(
        .BURST(BURST), .REFILL_PERIOD(REFILL_PERIOD)
    ) u_tokens (
        .clk(clk), .rst(rst), .req(ev_valid), .grant(grant), .level(tok_level)
    );

    tevt_fifo #(
        .W(REC_W), .DEPTH(DEPTH)
    ) u_fifo (
        .clk(clk), .rst(rst),
        .push(grant), .push_data({ts_q, info}), .full(fifo_full),
        .out_valid(rec_valid), .out_ready(rec_ready), .out_data(rec_word)
    );

    assign rec_ts   = rec_word[REC_W-1 -: TS_W];
    assign rec_info = rec_word[INFO_W-1:0];

    tevt_counters #(
        .CNT_W(CNT_W)
    ) u_counters (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .etype(ev_type_e'(ev_type)),
        .is_switch(moves_source(ev_from, ev_to)),
        .dropped(ev_valid && !grant),
        .type_cnt(type_cnt), .switch_cnt(switch_cnt), .drop_cnt(drop_cnt)
    );
endmodule

// File: rtl/tevt_logger_chk.sv
module tevt_logger_chk #(
    parameter int TS_W   = 32,
    parameter int INFO_W = 58,
    parameter int BURST  = 4,
    parameter int TOK_W  = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [TS_W-1:0]   ts_q,
    input logic [TOK_W-1:0]  tok_level,
    input logic              grant,
    input logic              fifo_full,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic [TS_W-1:0]   rec_ts,
    input logic [INFO_W-1:0] rec_info,
    input logic [CNT_W-1:0]  drop_cnt,
    input logic              overflow
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    a_r2_ts_step: assert property (@(posedge clk) disable iff (rst)
        armed |-> ts_q == $past(ts_q) + 1'b1);

    a_r6_tok_bound: assert property (@(posedge clk) disable iff (rst)
        tok_level <= TOK_W'(BURST));

    a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
        armed |-> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1));

    a_r3_push_shows: assert property (@(posedge clk) disable iff (rst)
        (grant && !fifo_full) |=> rec_valid);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(overflow)) |-> $past(grant && fifo_full));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_ts) && $stable(rec_info)));
endmodule

bind tevt_logger tevt_logger_chk #(
    .TS_W(TS_W), .INFO_W(tevt_pkg::INFO_W), .BURST(BURST),
    .TOK_W($clog2(BURST + 1)), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .ts_q(ts_q), .tok_level(tok_level), .grant(grant),
    .fifo_full(fifo_full), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_ts(rec_ts), .rec_info(rec_info), .drop_cnt(drop_cnt), .overflow(overflow)
);

// File: tb/tevt_logger_test.sv
module tevt_logger_test;
    import tevt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TS_W   = 8;
    localparam int BURST  = 3;
    localparam int REFILL = 8;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_valid = 1'b0;
    logic [1:0] ev_type = '0;
    logic [3:0] ev_from = '0, ev_to = '0, ev_ql = '0, ev_rsn_pri = '0, ev_rsn_sec = '0, ev_profile = '0;
    logic [2:0] ev_prio = '0, ev_timers = '0;
    logic [1:0] ev_state = '0;
    logic [7:0] ev_drift = '0;
    logic [15:0] ev_snap = '0;
    logic rec_valid, rec_ready = 1'b0;
    logic [TS_W-1:0] rec_ts;
    logic [INFO_W-1:0] rec_info;
    logic [4*CNT_W-1:0] type_cnt;
    logic [CNT_W-1:0] switch_cnt, drop_cnt;
    logic overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    tevt_logger #(
        .TS_W(TS_W), .BURST(BURST), .REFILL_PERIOD(REFILL), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_type(ev_type), .ev_from(ev_from),
        .ev_to(ev_to), .ev_ql(ev_ql), .ev_prio(ev_prio), .ev_timers(ev_timers),
        .ev_rsn_pri(ev_rsn_pri), .ev_rsn_sec(ev_rsn_sec), .ev_state(ev_state),
        .ev_drift(ev_drift), .ev_snap(ev_snap), .ev_profile(ev_profile),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_ts(rec_ts), .rec_info(rec_info),
        .type_cnt(type_cnt), .switch_cnt(switch_cnt), .drop_cnt(drop_cnt), .overflow(overflow)
    );

    typedef struct packed {
        logic [TS_W-1:0] ts;
        rec_info_t       info;
    } exp_rec_t;

    exp_rec_t   m_q[$];
    logic [TS_W-1:0] m_ts;
    int m_tok, m_rc, m_sw, m_drop;
    int m_tcnt[4];
    logic m_ovf;
    int vectors = 0, errors = 0, cycles = 0;
    bit done = 0;

    // Requirements model, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_ts = '0; m_tok = BURST; m_rc = 0; m_sw = 0; m_drop = 0; m_ovf = 1'b0;
            for (int k = 0; k < 4; k++) m_tcnt[k] = 0;
            m_q.delete();
        end else begin
            automatic bit full   = (m_q.size() == DEPTH);
            automatic bit pop_ok = (m_q.size() > 0) && rec_ready;
            automatic bit grant  = 1'b0;
            automatic bit tick   = (m_rc == REFILL - 1);
            automatic exp_rec_t r;
            if (ev_valid) begin
                m_tcnt[ev_type]++;
                if (ev_from != ev_to) m_sw++;
                if (m_tok > 0) grant = 1'b1; else m_drop++;
            end
            if (grant) begin
                r.ts = m_ts;
                r.info = '{etype: ev_type_e'(ev_type), src_from: ev_from, src_to: ev_to,
                           ql: ev_ql, prio: ev_prio, timers: timer_flags_t'(ev_timers),
                           rsn_pri: ev_rsn_pri, rsn_sec: ev_rsn_sec,
                           state: lock_state_e'(ev_state), drift: ev_drift,
                           snap: ev_snap, profile: ev_profile};
                if (!full) m_q.push_back(r); else m_ovf = 1'b1;
            end
            if (pop_ok) void'(m_q.pop_front());
            m_tok = m_tok - (grant ? 1 : 0) + (tick ? 1 : 0);
            if (m_tok > BURST) m_tok = BURST;
            m_rc = tick ? 0 : m_rc + 1;
            m_ts = m_ts + 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Outputs compared one edge after their cause, at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            chk(rec_valid == (m_q.size() > 0), "R9 rec_valid", rec_valid, m_q.size() > 0);
            if (rec_valid && m_q.size() > 0) begin
                chk(rec_ts == m_q[0].ts, "R2 record timestamp", rec_ts, m_q[0].ts);
                chk(rec_info == m_q[0].info, "R3 record body", rec_info, m_q[0].info);
            end
            for (int k = 0; k < 4; k++)
                chk(type_cnt[k*CNT_W +: CNT_W] == CNT_W'(m_tcnt[k]), "R4 type counter",
                    type_cnt[k*CNT_W +: CNT_W], m_tcnt[k]);
            chk(switch_cnt == CNT_W'(m_sw), "R5 switch counter", switch_cnt, m_sw);
            chk(drop_cnt == CNT_W'(m_drop), "R7 drop counter (R6 bucket)", drop_cnt, m_drop);
            chk(overflow == m_ovf, "R8 overflow flag", overflow, m_ovf);
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic offer(input int i);
        @(negedge clk);
        ev_valid   = 1'b1;
        ev_type    = 2'(i);
        ev_from    = 4'(i % 5);
        ev_to      = 4'((i * 3) % 7);
        ev_ql      = 4'(i * 7 + 1);
        ev_prio    = 3'(i + 2);
        ev_timers  = 3'(i * 5);
        ev_rsn_pri = 4'(i * 3 + 4);
        ev_rsn_sec = 4'(15 - i);
        ev_state   = 2'(i % 3);
        ev_drift   = 8'(i * 37);
        ev_snap    = 16'(i * 1009 + 5);
        ev_profile = 4'(i * 11);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            ev_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rec_valid == 1'b0, "R1 queue empty", rec_valid, 0);
        chk(type_cnt == '0 && switch_cnt == '0 && drop_cnt == '0, "R1 counters zero", type_cnt, 0);
        chk(overflow == 1'b0, "R1 overflow clear", overflow, 0);
        // R4/R6/R7: one of each type back to back, fourth finds bucket empty
        for (int i = 0; i < 4; i++) offer(i);
        idle(30);
        // R6/R7: storm
        for (int i = 4; i < 24; i++) offer(i);
        idle(30);
        // R8: fill queue past 16 with spaced events
        for (int i = 24; i < 44; i++) begin
            offer(i);
            idle(8);
        end
        // R9: drain with stalls
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            ev_valid  = 1'b0;
            rec_ready = (c % 3) != 0;
        end
        // R3/R9: events while reading alternately; timestamp wraps (R2)
        for (int i = 44; i < 84; i++) begin
            offer(i);
            rec_ready = i[0];
            idle(4);
        end
        rec_ready = 1'b1;
        idle(40);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule